// File: doc/BRIEF.md
# DC Bus Fault Ride-Through Sequencer

This block supervises a two-leg hybrid storage converter that uses a battery leg and a supercapacitor leg. It receives a stream of DC bus voltage samples and picks one of four operating modes. In precharge, the battery leg drives a small fixed current into the bus and the supercapacitor leg is parked. In normal mode, both legs follow their own control loops. In ride-through, the bus is shorted; the battery keeps injecting the small current so the bus refills by itself once the short is removed, and the supercapacitor leg stays off. In halt, every gate is off and only a manual reset releases the block.

For every mode it drives:
- a gate enable for each leg;
- an override for the battery current reference;
- a force-to-zero flag for the supercapacitor current reference;
- a select that switches the battery inductor-voltage limits to the fault pair, which is a minimum of zero and a maximum of the measured battery voltage.

A policy input picks what happens on a fault: ride-through, or immediate latch-off into halt. The sample input is a valid/ready stream. Ready is held high, so the block never applies back-pressure, and a sample is consumed on every cycle where valid is high. All other pins are plain level signals.

Top module: `frt_sequencer`

## Requirements
- R1: After reset the mode is precharge (code 0): the battery gate is on with its current overridden to `flt_iref`, the fault limit select is 1, the supercapacitor gate is off with its reference forced to zero, and `evt_o` is 0.
- R2: In precharge or ride-through, REC_RUN (default 2) consecutive samples with voltage at or above `rec_thresh` move the mode to normal (code 1). A sample below `rec_thresh` restarts the run.
- R3: In normal mode with `latch_off`=0, UV_RUN (default 3) consecutive samples strictly below `uv_thresh` move the mode to ride-through (code 2). A sample equal to or above `uv_thresh` restarts the run.
- R4: In ride-through the supercapacitor gate is off with its reference forced to zero, the battery gate is on, `bb_iref_ovr`=1 with `bb_iref_val`=`flt_iref`, and `bb_lim_fault`=1.
- R5: In normal mode both gates are on, `bb_iref_ovr`=0, `bb_iref_val`=0, `sc_iref_zero`=0 and `bb_lim_fault`=0.
- R6: In precharge or ride-through, the `tmo_limit`-th sample spent in that mode without completing recovery moves the mode to halt (code 3). A recovery completed on that same sample wins. In halt both gates are off.
- R7: With `latch_off`=1, a completed under-voltage run in normal mode moves the mode straight to halt.
- R8: Halt is left only through `man_rst`. `man_rst` high at a clock edge puts the block into precharge at that edge, whether or not a sample is present, and restarts all run and timeout counts.
- R9: The mode changes only at an edge where `smp_valid` or `man_rst` is high. `evt_o` is high for exactly the cycle that follows each mode change, and low otherwise.
- R10: `smp_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Bus voltage sample valid |
| smp_ready | output | 1 | Sample ready, held high |
| smp_volt | input | VW | Bus voltage sample |
| uv_thresh | input | VW | Under-voltage fault threshold |
| rec_thresh | input | VW | Recovery threshold |
| flt_iref | input | IW | Battery current reference used in precharge and ride-through |
| tmo_limit | input | TW | Samples allowed in precharge or ride-through before halt |
| latch_off | input | 1 | 1 selects latch-off on fault, 0 selects ride-through |
| man_rst | input | 1 | Manual reset to precharge |
| mode_o | output | 2 | Mode: 0 precharge, 1 normal, 2 ride-through, 3 halt |
| evt_o | output | 1 | One-cycle pulse after a mode change |
| bb_gate_en | output | 1 | Battery leg gate enable |
| sc_gate_en | output | 1 | Supercapacitor leg gate enable |
| bb_iref_ovr | output | 1 | Battery current reference override active |
| bb_iref_val | output | IW | Battery override current value |
| sc_iref_zero | output | 1 | Supercapacitor current reference forced to zero |
| bb_lim_fault | output | 1 | Selects the fault inductor-voltage limits for the battery leg |

## Verification
The bench sends several kinds of voltage sequences:
- Broken runs (a good sample followed by a bad one), which separate a true consecutive-sample count from a plain tally of samples.
- Samples exactly at each threshold, which pin down strict-below for faults and at-or-above for recovery.
- A persistent short under both policies, which separates the ride-through timeout path from the latch-off path.
- A timeout during precharge.

Idle stretches carry voltages that would cause a transition if they were sampled; these show that only strobed samples count. Manual resets are issued both from halt and from precharge, which checks the restart rule and that a reset with no mode change produces no event.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [1:0] {
    M_PRECHG = 2'd0,
    M_NORMAL = 2'd1,
    M_RIDE   = 2'd2,
    M_HALT   = 2'd3
  } mode_e;

  typedef struct packed {
    logic bb_gate;
    logic sc_gate;
    logic bb_ovr;
    logic sc_zero;
    logic lim_fault;
  } leg_ctl_t;
endpackage

// File: rtl/frt_run_count.sv
module frt_run_count #(
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic cond,
  input  logic clr,
  output logic hit
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] cnt_q;

  assign hit = step && cond && (cnt_q == CW'(RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (step) begin
      if (!cond || hit) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/frt_fault_timer.sv
module frt_fault_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   nxt;

  assign nxt    = {1'b0, cnt_q} + 1'b1;
  assign expire = step && (nxt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (step && !expire)  cnt_q <= nxt[TW-1:0];
  end
endmodule

// File: rtl/frt_out_decode.sv
module frt_out_decode
  import frt_pkg::*;
(
  input  mode_e    mode,
  output leg_ctl_t ctl
);
  always_comb begin
    ctl = '0;
    unique case (mode)
      M_PRECHG, M_RIDE: begin
        ctl.bb_gate   = 1'b1;
        ctl.bb_ovr    = 1'b1;
        ctl.sc_zero   = 1'b1;
        ctl.lim_fault = 1'b1;
      end
      M_NORMAL: begin
        ctl.bb_gate = 1'b1;
        ctl.sc_gate = 1'b1;
      end
      default: ctl.sc_zero = 1'b1;
    endcase
  end
endmodule

// File: rtl/frt_sequencer.sv
module frt_sequencer
  import frt_pkg::*;
#(
  parameter int VW      = 12,
  parameter int IW      = 10,
  parameter int TW      = 16,
  parameter int UV_RUN  = 3,
  parameter int REC_RUN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [VW-1:0] smp_volt,
  input  logic [VW-1:0] uv_thresh,
  input  logic [VW-1:0] rec_thresh,
  input  logic [IW-1:0] flt_iref,
  input  logic [TW-1:0] tmo_limit,
  input  logic          latch_off,
  input  logic          man_rst,
  output logic [1:0]    mode_o,
  output logic          evt_o,
  output logic          bb_gate_en,
  output logic          sc_gate_en,
  output logic          bb_iref_ovr,
  output logic [IW-1:0] bb_iref_val,
  output logic          sc_iref_zero,
  output logic          bb_lim_fault
);
  mode_e    state_q, state_d;
  logic     evt_q;
  logic     chg, clr;
  logic     in_fault_path;
  logic     uv_hit, rec_hit, tmo_hit;
  leg_ctl_t ctl;

  assign smp_ready     = 1'b1;
  assign in_fault_path = (state_q == M_PRECHG) || (state_q == M_RIDE);
  assign chg           = (state_d != state_q);
  assign clr           = chg || man_rst;

  frt_run_count #(.RUN(UV_RUN)) u_uv_run (
    .clk  (clk),
    .rst_n(rst_n),
    .step (smp_valid && (state_q == M_NORMAL)),
    .cond (smp_volt < uv_thresh),
    .clr  (clr),
    .hit  (uv_hit)
  );

  frt_run_count #(.RUN(REC_RUN)) u_rec_run (
    .clk  (clk),
    .rst_n(rst_n),
    .step (smp_valid && in_fault_path),
    .cond (smp_volt >= rec_thresh),
    .clr  (clr),
    .hit  (rec_hit)
  );

  frt_fault_timer #(.TW(TW)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (smp_valid && in_fault_path),
    .clr   (clr),
    .limit (tmo_limit),
    .expire(tmo_hit)
  );

  always_comb begin
    state_d = state_q;
    if (man_rst) begin
      state_d = M_PRECHG;
    end else begin
      unique case (state_q)
        M_PRECHG, M_RIDE: begin
          if (rec_hit)      state_d = M_NORMAL;
          else if (tmo_hit) state_d = M_HALT;
        end
        M_NORMAL: begin
          if (uv_hit) state_d = latch_off ? M_HALT : M_RIDE;
        end
        default: state_d = M_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_PRECHG;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= chg;
    end
  end

  frt_out_decode u_dec (
    .mode(state_q),
    .ctl (ctl)
  );

  assign mode_o       = state_q;
  assign evt_o        = evt_q;
  assign bb_gate_en   = ctl.bb_gate;
  assign sc_gate_en   = ctl.sc_gate;
  assign bb_iref_ovr  = ctl.bb_ovr;
  assign bb_iref_val  = ctl.bb_ovr ? flt_iref : '0;
  assign sc_iref_zero = ctl.sc_zero;
  assign bb_lim_fault = ctl.lim_fault;
endmodule

// File: rtl/frt_sequencer_chk.sv
module frt_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_valid,
  input logic       man_rst,
  input logic [1:0] mode_o,
  input logic       evt_o,
  input logic       sc_gate_en
);
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && !man_rst) |=> (mode_o == 2'd3));

  // R8
  mr_to_prechg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst |=> (mode_o == 2'd0));

  // R9
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !man_rst) |=> $stable(mode_o));

  // R9
  evt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (mode_o != $past(mode_o)));

  // R2
  sc_rise_on_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sc_gate_en) |-> $past(smp_valid));
endmodule

bind frt_sequencer frt_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .man_rst   (man_rst),
  .mode_o    (mode_o),
  .evt_o     (evt_o),
  .sc_gate_en(sc_gate_en)
);

// File: tb/frt_sequencer_tb.sv
`timescale 1ns/1ps
module frt_sequencer_tb;
  localparam int VW = 12, IW = 10, TW = 16, UV_RUN = 3, REC_RUN = 2;

  logic          clk = 0, rst_n = 0;
  logic          smp_valid = 0, smp_ready;
  logic [VW-1:0] smp_volt = 0;
  logic [VW-1:0] uv_thresh = 12'd15, rec_thresh = 12'd500;
  logic [IW-1:0] flt_iref = 10'd4;
  logic [TW-1:0] tmo_limit = 16'd20;
  logic          latch_off = 0, man_rst = 0;
  logic [1:0]    mode_o;
  logic          evt_o, bb_gate_en, sc_gate_en, bb_iref_ovr, sc_iref_zero, bb_lim_fault;
  logic [IW-1:0] bb_iref_val;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0] mode;
    logic       evt;
    logic [3:0] req;
  } exp_t;
  exp_t expq[$];

  int m_mode = 0, m_low = 0, m_high = 0, m_t = 0;

  always #4 clk = ~clk;

  frt_sequencer #(.VW(VW), .IW(IW), .TW(TW), .UV_RUN(UV_RUN), .REC_RUN(REC_RUN)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_volt(smp_volt), .uv_thresh(uv_thresh), .rec_thresh(rec_thresh),
    .flt_iref(flt_iref), .tmo_limit(tmo_limit), .latch_off(latch_off),
    .man_rst(man_rst), .mode_o(mode_o), .evt_o(evt_o), .bb_gate_en(bb_gate_en),
    .sc_gate_en(sc_gate_en), .bb_iref_ovr(bb_iref_ovr), .bb_iref_val(bb_iref_val),
    .sc_iref_zero(sc_iref_zero), .bb_lim_fault(bb_lim_fault)
  );

  task automatic chk(input bit ok, input int req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected leg outputs per mode (R1, R4, R5, R6)
  task automatic chk_outs(input int mode, input int req);
    logic [IW+4:0] act, exp;
    bit ovr;
    ovr = (mode == 0 || mode == 2);
    exp = {mode != 3, mode == 1, ovr, ovr ? flt_iref : {IW{1'b0}}, mode != 1, ovr};
    act = {bb_gate_en, sc_gate_en, bb_iref_ovr, bb_iref_val, sc_iref_zero, bb_lim_fault};
    chk(act == exp, req, "leg outputs", act, exp);
  endtask

  // Behavioural model built from R2, R3, R6, R7, R8
  task automatic model(input bit mr, input int volt, input int req);
    int nm;
    nm = m_mode;
    if (mr) begin
      nm = 0; m_low = 0; m_high = 0; m_t = 0;
    end else if (m_mode == 0 || m_mode == 2) begin
      m_high = (volt >= rec_thresh) ? m_high + 1 : 0;
      m_t++;
      if (m_high == REC_RUN) nm = 1;
      else if (m_t >= tmo_limit) nm = 3;
    end else if (m_mode == 1) begin
      m_low = (volt < uv_thresh) ? m_low + 1 : 0;
      if (m_low == UV_RUN) nm = latch_off ? 3 : 2;
    end
    if (nm != m_mode) begin m_low = 0; m_high = 0; m_t = 0; end
    expq.push_back('{mode: nm[1:0], evt: (nm != m_mode), req: req[3:0]});
    m_mode = nm;
  endtask

  task automatic smp(input int volt, input int req);
    @(negedge clk);
    smp_volt  = volt[VW-1:0];
    smp_valid = 1;
    model(0, volt, req);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic mreset(input int req);
    @(negedge clk);
    man_rst = 1;
    model(1, 0, req);
    @(negedge clk);
    man_rst = 0;
  endtask

  // Monitor: scoreboard pop on every consuming edge
  always @(posedge clk) begin
    if (rst_n && (smp_valid || man_rst)) begin
      exp_t e;
      #2;
      if (expq.size() == 0) begin
        chk(0, 9, "scoreboard empty", 0, 1);
      end else begin
        e = expq.pop_front();
        chk(mode_o == e.mode, int'(e.req), "mode", mode_o, e.mode);
        chk(evt_o == e.evt, 9, "evt", evt_o, e.evt); // R9
        chk_outs(int'(e.mode), int'(e.req));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(mode_o == 2'd0, 1, "reset mode", mode_o, 0);
    chk(evt_o == 0, 1, "reset evt", evt_o, 0);
    chk_outs(0, 1);
    // R10: ready held high
    chk(smp_ready == 1, 10, "ready", smp_ready, 1);

    // R2: broken recovery run in precharge, then a clean run
    smp(100, 2); smp(600, 2); smp(100, 2); smp(600, 2); smp(600, 2);
    // R3: broken low runs and boundary equal to uv_thresh
    smp(10, 3); smp(10, 3); smp(600, 3);
    smp(15, 3); smp(15, 3); smp(15, 3);
    // R3/R4: three low samples -> ride-through
    smp(10, 3); smp(10, 3); smp(10, 4);
    // R9: idle with recovering voltage must not change mode
    @(negedge clk);
    smp_volt = 12'd700;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(mode_o == 2'd2 && evt_o == 0, 9, "idle hold", {mode_o, evt_o}, 4);
    end
    // R2: boundary at rec_thresh, with one break
    smp(0, 4); smp(500, 2); smp(0, 2); smp(500, 2); smp(500, 5);
    // R5: stay normal on healthy samples
    smp(700, 5);
    // R6: persistent short, timeout of 5 samples
    tmo_limit = 16'd5;
    smp(5, 3); smp(5, 3); smp(5, 4);
    for (int i = 0; i < 5; i++) smp(0, 6);
    // R8: halt ignores recovery samples
    smp(600, 8); smp(600, 8); smp(600, 8);
    mreset(8);
    // R8: manual reset while in precharge: no event
    mreset(8);
    // R6: recovery on the timeout sample wins
    tmo_limit = 16'd2;
    smp(600, 6); smp(600, 6);
    // R7: latch-off policy
    latch_off = 1;
    smp(1, 7); smp(1, 7); smp(1, 7);
    smp(600, 8); smp(600, 8);
    mreset(8);
    latch_off = 0;
    // R6: precharge timeout
    tmo_limit = 16'd3;
    smp(600, 6); smp(0, 6); smp(0, 6);
    mreset(8);
    tmo_limit = 16'd20;
    smp(600, 2); smp(600, 2);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, 9, "scoreboard drained", expq.size(), 0);
    chk(smp_ready == 1, 10, "ready end", smp_ready, 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule